// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Demultiplexer

This block connects an 8-bit processor to its peripherals. The processor shares one set of pins between the low address byte and the data byte, and the block turns that shared bus into a separate address bus and a separate data path. It divides the 4 MHz input clock by four to make the 1 MHz E clock, which times every bus transfer. It also makes the address strobe. The strobe is high during the first input-clock period of the E-low half, and E rises one input-clock period after the strobe falls.

While the strobe is high, the low-address latch is transparent. When the strobe falls, the latch holds the low byte for the rest of the cycle. The upper address byte comes straight from dedicated pins. The full address is therefore valid through the whole cycle, including the E-high half, when the shared pins carry data.

The read/write line is combined with E to make the peripheral read and write enables. An inverted copy of the read/write line is also provided. Inside the chip the shared pins are modelled as separate input, output and output-enable signals. On a read, the block drives peripheral read data onto the shared pins only during the first E-high clock, so the pins are released before E falls.

Top module: `mux_bus_demux`

## Requirements
- R1: While reset is active and in the first cycles after it, E is 0, the strobe is 1, and the read enable, write enable and pad output enable are all 0.
- R2: E runs with a period of 4 input clocks: 2 clocks low, then 2 clocks high.
- R3: The strobe is 1 only during the first input clock of each E-low half. E rises exactly one input clock after the strobe falls.
- R4: While the strobe is 1, address bits 7:0 follow the shared-pin input with no delay (transparent latch).
- R5: After the strobe falls, address bits 7:0 hold the value the pins had in the strobe-high clock until the strobe rises again, whatever the pins do.
- R6: Address bits 15:8 always equal the upper-address input.
- R7: The read enable is 1 exactly when E is 1 and the read/write line is 1 (read).
- R8: The write enable is 1 exactly when E is 1 and the read/write line is 0 (write).
- R9: The pad output enable is 1 only in the first input clock of E-high during a read. During that clock the pad output equals the peripheral read data, and the enable is 0 again before E falls.
- R10: The inverted read/write output is always the complement of the read/write input.
- R11: The peripheral write data equals the shared-pin input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_e | output | 1 | 1 MHz E clock |
| bus_as | output | 1 | Address strobe |
| rw | input | 1 | Processor read/write line, 1 = read |
| hi_addr_in | input | 8 | Upper address byte from dedicated pins |
| ad_in | input | 8 | Shared pins, value coming from the processor |
| ad_out | output | 8 | Shared pins, value driven toward the processor |
| ad_oe | output | 1 | Output enable for ad_out |
| addr | output | 16 | Demultiplexed address |
| rd_data | input | 8 | Peripheral read data |
| wr_data | output | 8 | Peripheral write data |
| rd_en | output | 1 | Peripheral read enable |
| wr_en | output | 1 | Peripheral write enable |
| rw_n | output | 1 | Inverted read/write line |

## Verification
On every cycle, the assertions check the following:
- the shape of E and its timing against the strobe;
- that the latched low byte holds while the strobe is low;
- that the read and write enables are never both high;
- that the pad output enable appears only inside a read and lasts a single clock.

Only the bench's scenarios can show the values themselves. These include transparency of the low byte under a changing input while the strobe is high, read data reaching the pads, write data reaching the peripherals, the upper byte passing through, and the behaviour during reset.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [1:0] {
    PH_ADDR = 2'd0,
    PH_SETUP = 2'd1,
    PH_DATA0 = 2'd2,
    PH_DATA1 = 2'd3
  } bus_phase_t;
endpackage

// File: rtl/bus_phase_gen.sv
module bus_phase_gen
  import mux_bus_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  output bus_phase_t phase,
  output logic       e_clk,
  output logic       as_clk
);
  bus_phase_t phase_q, phase_d;

  always_comb begin
    phase_d = bus_phase_t'(phase_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_ADDR;
    else        phase_q <= phase_d;
  end

  assign phase  = phase_q;
  assign e_clk  = (phase_q == PH_DATA0) || (phase_q == PH_DATA1);
  assign as_clk = (phase_q == PH_ADDR);

  AST_E_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(e_clk) |=> e_clk); // R2
  AST_E_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (e_clk && $past(e_clk)) |=> !e_clk); // R2
  AST_AS_THEN_E: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(as_clk) |=> $rose(e_clk)); // R3
  AST_AS_E_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    as_clk |-> !e_clk); // R3
endmodule

// File: rtl/addr_latch.sv
module addr_latch #(
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe,
  input  logic [LO_W-1:0] pins,
  output logic [LO_W-1:0] lo_addr
);
  logic [LO_W-1:0] held_q, held_d;
  logic            cap_en;

  assign cap_en = strobe;

  always_comb begin
    held_d = held_q;
    if (cap_en) held_d = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign lo_addr = strobe ? pins : held_q;

  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && $past(!strobe)) |-> $stable(lo_addr)); // R5
endmodule

// File: rtl/strobe_qual.sv
module strobe_qual
  import mux_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_phase_t        phase,
  input  logic              e_clk,
  input  logic              rw,
  input  logic [DATA_W-1:0] periph_rd,
  output logic [DATA_W-1:0] pad_out,
  output logic              pad_oe,
  output logic              rd_en,
  output logic              wr_en,
  output logic              rw_n
);
  always_comb begin
    rd_en   = e_clk & rw;
    wr_en   = e_clk & ~rw;
    rw_n    = ~rw;
    pad_oe  = rst_n & rw & (phase == PH_DATA0);
    pad_out = pad_oe ? periph_rd : '0;
  end

  AST_EN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R7
  AST_OE_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> (rd_en && e_clk)); // R9
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |=> (!pad_oe && e_clk)); // R9
endmodule

// File: rtl/mux_bus_demux.sv
module mux_bus_demux
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              bus_e,
  output logic              bus_as,
  input  logic              rw,
  input  logic [HI_W-1:0]   hi_addr_in,
  input  logic [DATA_W-1:0] ad_in,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_en,
  output logic              wr_en,
  output logic              rw_n
);
  logic       sync1_q, rst_s;
  bus_phase_t phase;
  logic       e_int, as_int;
  logic [DATA_W-1:0] lo_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      rst_s   <= 1'b0;
    end else begin
      sync1_q <= 1'b1;
      rst_s   <= sync1_q;
    end
  end

  bus_phase_gen u_phase (
    .clk(clk), .rst_n(rst_s), .phase(phase), .e_clk(e_int), .as_clk(as_int)
  );

  addr_latch #(.LO_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_s), .strobe(as_int), .pins(ad_in), .lo_addr(lo_addr)
  );

  strobe_qual #(.DATA_W(DATA_W)) u_qual (
    .clk(clk), .rst_n(rst_s), .phase(phase), .e_clk(e_int), .rw(rw),
    .periph_rd(rd_data), .pad_out(ad_out), .pad_oe(ad_oe),
    .rd_en(rd_en), .wr_en(wr_en), .rw_n(rw_n)
  );

  assign bus_e   = e_int;
  assign bus_as  = as_int;
  assign addr    = {hi_addr_in, lo_addr};
  assign wr_data = ad_in;

  AST_HI_PASS: assert property (@(posedge clk) disable iff (!rst_s)
    addr[ADDR_W-1:DATA_W] == hi_addr_in); // R6
endmodule

// File: tb/tb_mux_bus_demux.sv
`timescale 1ns/1ps
module tb_mux_bus_demux;
  localparam int CLK_PERIOD = 250;

  logic clk = 1'b0, rst_n = 1'b0, rw = 1'b1;
  logic [7:0] hi_addr_in = '0, ad_in = '0, rd_data = '0;
  logic bus_e, bus_as, ad_oe, rd_en, wr_en, rw_n;
  logic [7:0] ad_out, wr_data;
  logic [15:0] addr;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_demux dut (
    .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_as(bus_as), .rw(rw),
    .hi_addr_in(hi_addr_in), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .addr(addr), .rd_data(rd_data), .wr_data(wr_data), .rd_en(rd_en),
    .wr_en(wr_en), .rw_n(rw_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic align();
    do @(negedge clk); while (bus_as !== 1'b0);
    do @(negedge clk); while (bus_as !== 1'b1);
  endtask

  task automatic test_reset();
    #1;
    check(bus_e === 1'b0, "R1 e", bus_e, 0);
    check(bus_as === 1'b1, "R1 as", bus_as, 1);
    check({rd_en, wr_en, ad_oe} === 3'b000, "R1 enables", {rd_en, wr_en, ad_oe}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(bus_as === 1'b1 && bus_e === 1'b0, "R1 post-release", {bus_as, bus_e}, 2);
  endtask

  task automatic bus_cycle(input bit rd, input logic [7:0] hi, input logic [7:0] lo,
                           input logic [7:0] dat);
    align();
    rw = rd; hi_addr_in = hi; ad_in = lo; rd_data = dat;
    #1;
    check(addr[7:0] === lo, "R4 transparent", addr[7:0], lo);
    check(bus_e === 1'b0, "R3 e low with as", bus_e, 0);
    check(rw_n === ~rd, "R10 rw_n", rw_n, ~rd);
    ad_in = ~lo; #1;
    check(addr[7:0] === ~lo, "R4 follows change", addr[7:0], ~lo);
    ad_in = lo;
    @(negedge clk);
    ad_in = lo ^ 8'h5A; #1;
    check(bus_as === 1'b0 && bus_e === 1'b0, "R3 setup clock", {bus_as, bus_e}, 0);
    check(addr[7:0] === lo, "R5 hold", addr[7:0], lo);
    check(addr[15:8] === hi, "R6 upper", addr[15:8], hi);
    @(negedge clk);
    ad_in = dat; #1;
    check(bus_e === 1'b1, "R3 e rises", bus_e, 1);
    check(addr === {hi, lo}, "R5 addr in data phase", addr, {hi, lo});
    if (rd) begin
      check(rd_en === 1'b1 && wr_en === 1'b0, "R7 read enable", {rd_en, wr_en}, 2);
      check(ad_oe === 1'b1, "R9 oe on", ad_oe, 1);
      check(ad_out === dat, "R9 pad data", ad_out, dat);
    end else begin
      check(wr_en === 1'b1 && rd_en === 1'b0, "R8 write enable", {rd_en, wr_en}, 1);
      check(ad_oe === 1'b0, "R9 no oe on write", ad_oe, 0);
      check(wr_data === dat, "R11 write data", wr_data, dat);
    end
    @(negedge clk); #1;
    check(bus_e === 1'b1, "R2 e high second clock", bus_e, 1);
    check(ad_oe === 1'b0, "R9 released", ad_oe, 0);
    check(rd_en === rd && wr_en === !rd, "R7 R8 hold", {rd_en, wr_en}, {rd, !rd});
    @(negedge clk); #1;
    check(bus_e === 1'b0 && bus_as === 1'b1, "R2 period", {bus_e, bus_as}, 1);
    check({rd_en, wr_en} === 2'b00, "R7 R8 off", {rd_en, wr_en}, 0);
  endtask

  initial begin
    test_reset();
    bus_cycle(1'b1, 8'hA5, 8'h3C, 8'hE7);
    bus_cycle(1'b0, 8'h12, 8'hF0, 8'h81);
    bus_cycle(1'b1, 8'hFF, 8'h00, 8'h00);
    bus_cycle(1'b0, 8'h00, 8'hFF, 8'hFF);
    bus_cycle(1'b1, 8'h7E, 8'h55, 8'hAA);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule